// File: doc/BRIEF.md
# Byte-Swapped Interrupt Aggregation Controller

This block gathers up to sixty-four level-sensitive interrupt sources, split into a low bank and a high bank of up to 32 lines each, and folds them into one interrupt line toward a processor. Each bank keeps a registered copy of its source levels and an enable mask. Software can read the enabled-and-pending view, read and write the mask, and write a clear word. The processor line is high whenever any bank holds a bit that is both set and enabled.

The host side is a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Data on this port is byte-reversed in both directions. Besides the bank registers, the port offers a fixed version word, a timer-frequency word that always reads zero, and a read-only vector word for every other offset. The vector number in that word is derived from the access offset.

Top module: `irq_aggregator`

## Requirements
- R1: Each status bit takes the level of its source line at every clock edge, so a source change shows in status one cycle later. `src_lo_i` feeds the low bank and `src_hi_i` feeds the high bank.
- R2: `cpu_irq_o` is high exactly when (low status AND low enable) OR (high status AND high enable) is nonzero, using the registered state.
- R3: A read of offset 0x20 returns low status AND low enable. A read of 0x10 returns the same for the high bank. Both are given in bus byte order.
- R4: A write to 0x24 (low) or 0x14 (high) replaces that bank's enable mask, and a read of the same offset returns it. `cpu_irq_o` reflects the new mask from the edge that stores it, whether the line rises or falls.
- R5: A write to 0x28 (low) or 0x18 (high) clears, for one cycle, every status bit whose data bit is 1. Bits written as 0 are untouched. A source that is still high sets its bit again at the next edge.
- R6: The port byte order is reversed. Bus bits [7:0], [15:8], [23:16] and [31:24] map to internal bits [31:24], [23:16], [15:8] and [7:0]. This applies to write data and to read data.
- R7: Offset 0x00 reads the internal word 0x00190002, which is 0x02001900 on the bus. Offset 0xF0 reads 0. Writes to both offsets change no state.
- R8: A read of any offset that is not decoded returns the internal word 0x80000000 OR v, where v = ((((offset - 0x120) AND 0xFFF) >> 6) AND 0xFF) + 0x40. Bit 31 is the mask flag and bits 7:0 are the vector. Writes to such offsets change no state.
- R9: Offsets 0x18, 0x1C, 0x28 and 0x2C read as zero. Writes to 0x1C and 0x2C change no state.
- R10: Reset clears all status and enable bits, so `cpu_irq_o` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lo_i | input | BANK_W | Low bank source levels |
| src_hi_i | input | BANK_W | High bank source levels |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data in bus byte order |
| bus_rdata_o | output | 32 | Read data in bus byte order, combinational on the address |
| cpu_irq_o | output | 1 | Aggregated interrupt to the processor |

## Verification
A status or mask bit stored in the wrong state appears on `cpu_irq_o` at the very next edge and in the masked read one cycle after the source changes. A wrong byte lane shows as a rotated pattern in the first enable read-back. A wrong vector computation shows up in the offset sweep. The sweep covers every word offset below 0x400 and compares each one against arithmetic done in the bench.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [2:0] {
      RK_VERSION,
      RK_TIMER,
      RK_MASKED,
      RK_ENABLE,
      RK_CLEAR,
      RK_RESERVED,
      RK_VECTOR
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e kind;
      logic      bank;   // 1: high bank, 0: low bank
   } decode_t;

   function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
      logic [WORD_W-1:0] r;
      for (int b = 0; b < WORD_W / 8; b++) begin
         r[8*b +: 8] = w[WORD_W - 8*(b+1) +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
   import irqagg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 18,
   parameter int unsigned VERSION_OFS = 32'h00,
   parameter int unsigned TIMER_OFS   = 32'hF0,
   parameter int unsigned HI_BASE     = 32'h10,
   parameter int unsigned LO_BASE     = 32'h20
) (
   input  logic [ADDR_W-1:0] addr_i,
   output decode_t           dec_o
);

   localparam int unsigned N_SLOT = 4;

   logic [1:0][N_SLOT-1:0] hit;

   for (genvar b = 0; b < 2; b++) begin : g_bank_hit
      localparam int unsigned BASE = (b == 1) ? HI_BASE : LO_BASE;
      for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
         assign hit[b][s] = (addr_i == ADDR_W'(BASE + 4*s));
      end
   end

   always_comb begin
      dec_o.bank = 1'b0;
      dec_o.kind = RK_VECTOR;
      if (addr_i == ADDR_W'(VERSION_OFS)) begin
         dec_o.kind = RK_VERSION;
      end else if (addr_i == ADDR_W'(TIMER_OFS)) begin
         dec_o.kind = RK_TIMER;
      end else if (|hit[0] || |hit[1]) begin
         dec_o.bank = |hit[1];
         case (hit[0] | hit[1])
            4'b0001: dec_o.kind = RK_MASKED;
            4'b0010: dec_o.kind = RK_ENABLE;
            4'b0100: dec_o.kind = RK_CLEAR;
            default: dec_o.kind = RK_RESERVED;
         endcase
      end
   end

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
   parameter int unsigned BANK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_i,
   input  logic              en_we_i,
   input  logic              clr_we_i,
   input  logic [BANK_W-1:0] wval_i,
   output logic [BANK_W-1:0] masked_o,
   output logic [BANK_W-1:0] enable_o,
   output logic              pend_o
);

   logic [BANK_W-1:0] status_q;
   logic [BANK_W-1:0] enable_q;
   logic [BANK_W-1:0] clr_mask;

   assign clr_mask = clr_we_i ? wval_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= src_i & ~clr_mask;
         if (en_we_i) begin
            enable_q <= wval_i;
         end
      end
   end

   assign masked_o = status_q & enable_q;
   assign enable_o = enable_q;
   assign pend_o   = |masked_o;

   // R1: no status bit without its source high on the previous edge
   p_status_has_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~$past(src_i)) == '0);

   // R5: a cleared bit stays low for the cycle after the clear
   p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_we_i) |-> (status_q & $past(wval_i)) == '0);

   // R4: an enable write is stored as given
   p_enable_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_we_i) |-> enable_q == $past(wval_i));

   // R9: without an enable write the mask holds
   p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_we_i) |-> $stable(enable_q));

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
   import irqagg_pkg::*;
#(
   parameter int unsigned ADDR_W          = 18,
   parameter int unsigned BANK_W          = 32,
   parameter logic [31:0] VERSION_WORD    = 32'h0019_0002,
   parameter int unsigned VEC_ORIGIN      = 32'h120,
   parameter int unsigned VEC_BASE        = 32'h40,
   parameter int unsigned VEC_STRIDE_LOG2 = 6
) (
   input  logic [ADDR_W-1:0]         addr_i,
   input  decode_t                   dec_i,
   input  logic [1:0][BANK_W-1:0]    masked_i,
   input  logic [1:0][BANK_W-1:0]    enable_i,
   output logic [WORD_W-1:0]         rdata_o
);

   localparam logic [WORD_W-1:0] MASK_FLAG = 32'h8000_0000;

   logic [11:0]       rel;
   logic [7:0]        vnum;
   logic [WORD_W-1:0] word;

   assign rel  = 12'(addr_i - ADDR_W'(VEC_ORIGIN));
   assign vnum = 8'(rel >> VEC_STRIDE_LOG2) + 8'(VEC_BASE);

   always_comb begin
      unique case (dec_i.kind)
         RK_VERSION: word = VERSION_WORD;
         RK_MASKED:  word = WORD_W'(masked_i[dec_i.bank]);
         RK_ENABLE:  word = WORD_W'(enable_i[dec_i.bank]);
         RK_VECTOR:  word = MASK_FLAG | WORD_W'(vnum);
         default:    word = '0;
      endcase
   end

   assign rdata_o = swap_bytes(word);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irqagg_pkg::*;
#(
   parameter int unsigned ADDR_W          = 18,
   parameter int unsigned BANK_W          = 32,
   parameter logic [31:0] VERSION_WORD    = 32'h0019_0002,
   parameter int unsigned VERSION_OFS     = 32'h00,
   parameter int unsigned TIMER_OFS       = 32'hF0,
   parameter int unsigned HI_BASE         = 32'h10,
   parameter int unsigned LO_BASE         = 32'h20,
   parameter int unsigned VEC_ORIGIN      = 32'h120,
   parameter int unsigned VEC_BASE        = 32'h40,
   parameter int unsigned VEC_STRIDE_LOG2 = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_lo_i,
   input  logic [BANK_W-1:0] src_hi_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              cpu_irq_o
);

   localparam int unsigned N_BANK = 2;

   if (BANK_W < 1 || BANK_W > WORD_W) begin : g_bad_bank_w
      $error("BANK_W must lie in 1..32");
   end
   if (ADDR_W < 12) begin : g_bad_addr_w
      $error("ADDR_W must be at least 12");
   end
   if (VEC_STRIDE_LOG2 < 4 || VEC_STRIDE_LOG2 > 11) begin : g_bad_stride
      $error("VEC_STRIDE_LOG2 must lie in 4..11");
   end

   decode_t                     dec;
   logic [WORD_W-1:0]           wval;
   logic [N_BANK-1:0][BANK_W-1:0] src_arr;
   logic [N_BANK-1:0][BANK_W-1:0] masked_arr;
   logic [N_BANK-1:0][BANK_W-1:0] enable_arr;
   logic [N_BANK-1:0]           pend;

   assign wval       = swap_bytes(bus_wdata_i);
   assign src_arr[0] = src_lo_i;
   assign src_arr[1] = src_hi_i;

   irqagg_decode #(
      .ADDR_W      (ADDR_W),
      .VERSION_OFS (VERSION_OFS),
      .TIMER_OFS   (TIMER_OFS),
      .HI_BASE     (HI_BASE),
      .LO_BASE     (LO_BASE)
   ) u_decode (
      .addr_i (bus_addr_i),
      .dec_o  (dec)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      logic sel;
      assign sel = bus_wr_i && (dec.bank == 1'(b));
      irqagg_bank #(.BANK_W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_i    (src_arr[b]),
         .en_we_i  (sel && dec.kind == RK_ENABLE),
         .clr_we_i (sel && dec.kind == RK_CLEAR),
         .wval_i   (wval[BANK_W-1:0]),
         .masked_o (masked_arr[b]),
         .enable_o (enable_arr[b]),
         .pend_o   (pend[b])
      );
   end

   irqagg_rdmux #(
      .ADDR_W          (ADDR_W),
      .BANK_W          (BANK_W),
      .VERSION_WORD    (VERSION_WORD),
      .VEC_ORIGIN      (VEC_ORIGIN),
      .VEC_BASE        (VEC_BASE),
      .VEC_STRIDE_LOG2 (VEC_STRIDE_LOG2)
   ) u_rdmux (
      .addr_i   (bus_addr_i),
      .dec_i    (dec),
      .masked_i (masked_arr),
      .enable_i (enable_arr),
      .rdata_o  (bus_rdata_o)
   );

   assign cpu_irq_o = |pend;

   // R2: the line needs an enabled bit somewhere
   p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o |-> ((|enable_arr[0]) || (|enable_arr[1])));

   // R2: the line needs a source that was high on the previous edge
   p_irq_needs_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_o |-> $past((|src_lo_i) || (|src_hi_i)));

   // R9: reserved slots read as zero
   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_W'(HI_BASE + 12) || bus_addr_i == ADDR_W'(LO_BASE + 12))
      |-> bus_rdata_o == '0);

   // R7: the version offset reads the fixed word
   p_version_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_W'(VERSION_OFS)) |-> bus_rdata_o == 32'h0200_1900);

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

   localparam int ADDR_W = 18;
   localparam int BANK_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [BANK_W-1:0] src_lo = '0;
   logic [BANK_W-1:0] src_hi = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr = 1'b0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_aggregator #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_lo_i    (src_lo),
      .src_hi_i    (src_hi),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cpu_irq_o   (irq)
   );

   function automatic logic [31:0] flip32(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // write: drive after a falling edge, stored at the next rising edge
   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      addr = ADDR_W'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      addr = ADDR_W'(a);
      #1;
      d = rdata;
   endtask

   task automatic set_src(input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      src_lo = lo; src_hi = hi;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 irq", 32'(irq), 0);
      bus_read(32'h24, r); check("R10 enable lo", r, 0);
      bus_read(32'h14, r); check("R10 enable hi", r, 0);
      bus_read(32'h20, r); check("R10 masked lo", r, 0);

      // R7 fixed words
      bus_read(32'h00, r); check("R7 version", r, 32'h0200_1900);
      bus_read(32'hF0, r); check("R7 timer", r, 0);

      // R7 R8 R9 ignored writes
      bus_write(32'h00, '1);
      bus_write(32'hF0, '1);
      bus_write(32'h1C, '1);
      bus_write(32'h2C, '1);
      bus_write(32'h300, '1);
      bus_read(32'h24, r); check("R9 enable lo after ignored writes", r, 0);
      bus_read(32'h14, r); check("R9 enable hi after ignored writes", r, 0);
      bus_read(32'h00, r); check("R7 version after write", r, 32'h0200_1900);
      bus_read(32'h1C, r); check("R9 reserved hi", r, 0);
      bus_read(32'h2C, r); check("R9 reserved lo", r, 0);
      bus_read(32'h18, r); check("R9 clear hi reads zero", r, 0);
      bus_read(32'h28, r); check("R9 clear lo reads zero", r, 0);

      // R6 byte order on enable round trip and masked view
      bus_write(32'h24, 32'h1234_5678);
      bus_read(32'h24, r); check("R6 enable round trip", r, 32'h1234_5678);
      set_src(32'h0000_0410, 0);
      bus_read(32'h20, r);
      check("R6 masked lane order", r, flip32(32'h0000_0410 & 32'h7856_3412));
      check("R2 irq mixed", 32'(irq), 1);

      // R1 R3 walking sweep, both banks fully enabled
      bus_write(32'h24, '1);
      bus_write(32'h14, '1);
      for (int i = 0; i < BANK_W; i++) begin
         logic [31:0] b;
         b = 32'h1 << i;
         set_src(b, ~b);
         bus_read(32'h20, r); check("R1 R3 low walking", r, flip32(b));
         bus_read(32'h10, r); check("R1 R3 high walking", r, flip32(~b));
         check("R2 irq walking", 32'(irq), 1);
      end
      set_src(0, 0);
      check("R1 irq after sources drop", 32'(irq), 0);

      // R1 one-cycle lag of status
      @(negedge clk);
      src_lo = 32'h8000_0001;
      bus_read(32'h20, r); check("R1 before edge", r, 0);
      @(negedge clk);
      bus_read(32'h20, r); check("R1 after edge", r, flip32(32'h8000_0001));
      src_lo = 0;

      // R2 R4 mixed patterns on the low bank
      bus_write(32'h14, 0);
      for (int k = 0; k < 10; k++) begin
         logic [31:0] s, e;
         s = 32'h9E37_79B9 * (k + 1);
         e = (k == 9) ? 32'h0 : (32'h7F4A_7C15 ^ (32'h0101_0101 * k)) >> k;
         set_src(s, 0);
         bus_write(32'h24, flip32(e));
         check("R4 irq follows mask at once", 32'(irq), 32'(|(s & e)));
         bus_read(32'h20, r); check("R3 masked pattern", r, flip32(s & e));
         bus_read(32'h24, r); check("R4 enable read back", r, flip32(e));
      end

      // R4 rise and fall on the high bank
      bus_write(32'h24, 0);
      set_src(0, 32'h20);
      check("R4 low before enable", 32'(irq), 0);
      bus_write(32'h14, flip32(32'h20));
      check("R4 rise on enable", 32'(irq), 1);
      bus_write(32'h14, 0);
      check("R4 fall on disable", 32'(irq), 0);

      // R5 clear semantics, low bank
      bus_write(32'h24, '1);
      set_src(32'h3, 0);
      bus_write(32'h28, flip32(32'h1));
      bus_read(32'h20, r); check("R5 cleared bit low for one cycle", r, flip32(32'h2));
      check("R5 irq held by other bit", 32'(irq), 1);
      @(negedge clk);
      bus_read(32'h20, r); check("R5 level source returns", r, flip32(32'h3));
      bus_write(32'h28, 0);
      bus_read(32'h20, r); check("R5 zero clear word no effect", r, flip32(32'h3));
      set_src(32'h1, 0);
      bus_write(32'h28, flip32(32'h1));
      check("R5 irq dips on clear", 32'(irq), 0);
      @(negedge clk);
      check("R5 irq back while source high", 32'(irq), 1);

      // R5 clear on the high bank
      bus_write(32'h24, 0);
      bus_write(32'h14, '1);
      set_src(0, 32'hF000_000F);
      bus_write(32'h18, flip32(32'hF000_0000));
      bus_read(32'h10, r); check("R5 high clear", r, flip32(32'h0000_000F));

      // R8 vector sweep
      for (int off = 0; off < 32'h400; off += 4) begin
         logic [31:0] exp;
         if (off == 0 || off == 32'hF0 || (off >= 32'h10 && off < 32'h30)) continue;
         exp = 32'h8000_0000 | (((((off - 32'h120) & 32'hFFF) / 32'h40) & 32'hFF) + 32'h40);
         bus_read(off, r);
         check("R8 vector word", r, flip32(exp));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule